// File: doc/BRIEF.md
# Multi-Mode Baud Tick Generator

This block turns the core clock into the timing strobes a UART needs. A 16-bit divisor A and a 4-bit divisor B, together with two mode bits, pick one of three division schemes. A first counter stage divides the clock by A + 2 and marks each wrap with an oversampling strobe. A second stage counts those strobes and emits a one-cycle bit strobe at the serial bit rate.

The mode is set by a divide-X enable bit and a divide-X-one bit. With divide-X off, the bit rate is clk / (16 × (A + 2)). With divide-X on and divide-X-one clear, it is clk / ((B + 1) × (A + 2)). With both bits set, every first-stage wrap is a bit strobe, giving clk / (A + 2), and no oversampling strobe is produced.

A single write strobe loads divisors and mode together. It restarts both counters on the same edge, so the new rate starts from a clean period and no shortened period appears. Settings below the legal minimum are raised to that minimum and flagged.

Top module: `baud_divider`

## Requirements
- R1: While rst_n is low, samp_tick, bit_tick and cfg_err are 0. After reset the divider runs with A = 0 in the sixteen-times mode: samp_tick first rises in cycle 1 and bit_tick in cycle 31, counting the first cycle with rst_n high as cycle 0.
- R2: With cfg_divx_en = 0 as loaded, bit_tick pulses once every 16 × (A + 2) cycles.
- R3: With cfg_divx_en = 1 and cfg_divx_one = 0 as loaded, bit_tick pulses once every (B + 1) × (A + 2) cycles.
- R4: With cfg_divx_en = 1 and cfg_divx_one = 1 as loaded, bit_tick pulses once every (A + 2) cycles, and samp_tick stays 0.
- R5: In the two oversampling modes, samp_tick pulses once every A + 2 cycles. Every bit_tick falls in a cycle where samp_tick is also 1, and each bit period holds exactly 16 (or B + 1) samp_tick pulses.
- R6: In the B + 1 mode, a loaded B below 8 is treated as 8, and cfg_err reads 1 from the cycle after the write.
- R7: In the single-stage mode, a loaded A below 3 is treated as 3, and cfg_err reads 1. A write with a legal setting clears cfg_err. cfg_err changes only on a write.
- R8: The edge that samples cfg_wr = 1 loads the new setting and restarts both counters. Counting the next cycle as cycle 0, samp_tick first rises in cycle A + 1 and bit_tick in cycle N × (A + 2) − 1, where N is the bit period in samp_tick pulses. Neither strobe is 1 in cycle 0.
- R9: A write in the same cycle as a bit_tick leaves that strobe intact, and the new period starts on the following cycle.
- R10: cfg_divx_one has no effect when cfg_divx_en = 0. The sixteen-times rate applies and cfg_err stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Load strobe for divisors and mode; restarts counters |
| cfg_a | input | 16 | Divisor A |
| cfg_b | input | 4 | Divisor B |
| cfg_divx_en | input | 1 | Divide-X enable |
| cfg_divx_one | input | 1 | Divide-X-one select |
| samp_tick | output | 1 | Oversampling strobe, one cycle wide |
| bit_tick | output | 1 | Bit-rate strobe, one cycle wide |
| cfg_err | output | 1 | Loaded setting was below its legal minimum |

## Verification
A configuration write and a terminal count can land on the same edge. The bench provokes this by waiting, in the single-stage mode, for a cycle where bit_tick is high and raising cfg_wr in that same cycle with a new divisor. Two things are judged. First, the strobe already on the output is observed as 1. Second, the next bit_tick arrives exactly A_new + 1 cycles after the write edge, with no extra or shortened period. The full sweeps over small A and over every B also write while the counters are mid-period, which shows that a restart never leaves a shortened first period.

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int AW = 16,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [AW-1:0] cfg_a,
  input  logic [BW-1:0] cfg_b,
  input  logic          cfg_divx_en,
  input  logic          cfg_divx_one,
  output logic          samp_tick,
  output logic          bit_tick,
  output logic          cfg_err
);
  localparam int CW = AW + 1;
  localparam int NW = (BW + 1 > 5) ? BW + 1 : 5;
  localparam logic [AW-1:0] A_MIN = AW'(3);
  localparam logic [BW-1:0] B_MIN = BW'(8);

  logic [CW-1:0] top_q, cnt1;
  logic [NW-1:0] last_q, cnt2;
  logic          direct_q, err_q;

  logic          direct_n, bsel_n, a_low, b_low;
  logic [AW-1:0] a_eff;
  logic [BW-1:0] b_eff;
  logic [CW-1:0] top_n;
  logic [NW-1:0] last_n;
  logic          wrap1;

  assign direct_n = cfg_divx_en & cfg_divx_one;
  assign bsel_n   = cfg_divx_en & ~cfg_divx_one;
  assign a_low    = direct_n && (cfg_a < A_MIN);
  assign b_low    = bsel_n && (cfg_b < B_MIN);
  assign a_eff    = a_low ? A_MIN : cfg_a;
  assign b_eff    = b_low ? B_MIN : cfg_b;
  assign top_n    = {1'b0, a_eff} + CW'(1);
  assign last_n   = direct_n ? '0 : (bsel_n ? NW'(b_eff) : NW'(15));

  assign wrap1     = (cnt1 == top_q);
  assign samp_tick = wrap1 & ~direct_q;
  assign bit_tick  = wrap1 && (cnt2 == last_q);
  assign cfg_err   = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_q    <= CW'(1);
      last_q   <= NW'(15);
      direct_q <= 1'b0;
      err_q    <= 1'b0;
      cnt1     <= '0;
      cnt2     <= '0;
    end else if (cfg_wr) begin
      top_q    <= top_n;
      last_q   <= last_n;
      direct_q <= direct_n;
      err_q    <= a_low | b_low;
      cnt1     <= '0;
      cnt2     <= '0;
    end else if (wrap1) begin
      cnt1 <= '0;
      cnt2 <= (cnt2 == last_q) ? '0 : cnt2 + NW'(1);
    end else begin
      cnt1 <= cnt1 + CW'(1);
    end
  end
endmodule

// File: rtl/baud_divider_chk.sv
module baud_divider_chk #(
  parameter int AW = 16,
  parameter int BW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr,
  input logic [AW-1:0] cfg_a,
  input logic [BW-1:0] cfg_b,
  input logic          cfg_divx_en,
  input logic          cfg_divx_one,
  input logic          samp_tick,
  input logic          bit_tick,
  input logic          cfg_err,
  input logic          direct_q
);
  a_r4_direct_no_samp: assert property (@(posedge clk) disable iff (!rst_n)
    direct_q |-> !samp_tick);
  a_r5_bit_on_samp: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !direct_q) |-> samp_tick);
  a_r5_samp_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    samp_tick |=> !samp_tick);
  a_r4_bit_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);
  a_r8_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (!samp_tick && !bit_tick));
  a_r6_b_clamp_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_divx_en && !cfg_divx_one && cfg_b < BW'(8)) |=> cfg_err);
  a_r7_a_clamp_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_divx_en && cfg_divx_one && cfg_a < AW'(3)) |=> cfg_err);
  a_r10_x16_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_divx_en) |=> !cfg_err);
  a_r7_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg_err));
endmodule

bind baud_divider baud_divider_chk #(.AW(AW), .BW(BW)) u_chk (.*);

// File: tb/baud_divider_tb.sv
module baud_divider_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_a = '0;
  logic [3:0]  cfg_b = '0;
  logic        cfg_divx_en = 1'b0;
  logic        cfg_divx_one = 1'b0;
  logic        samp_tick, bit_tick, cfg_err;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  baud_divider u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_a(cfg_a), .cfg_b(cfg_b),
    .cfg_divx_en(cfg_divx_en), .cfg_divx_one(cfg_divx_one),
    .samp_tick(samp_tick), .bit_tick(bit_tick), .cfg_err(cfg_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic observe(input int span, output int fs, output int fb, output int sb,
                         output int sc, input int per);
    fs = -1; fb = -1; sb = -1; sc = 0;
    for (int k = 0; k < span; k++) begin
      if (samp_tick) begin
        if (fs < 0) fs = k;
        if (k < per) sc++;
      end
      if (bit_tick) begin
        if (fb < 0) fb = k;
        else if (sb < 0) sb = k;
      end
      @(negedge clk);
    end
  endtask

  task automatic run_cfg(input int a, input int b, input bit en, input bit one);
    int ea, n, p, per, fs, fb, sb, sc;
    bit err;
    string tag;
    ea = a; err = 0;
    if (en && one) begin
      n = 1; tag = "R4";
      if (a < 3) begin ea = 3; err = 1; tag = "R7"; end
    end else if (en) begin
      n = (b < 8 ? 8 : b) + 1; tag = "R3";
      if (b < 8) begin err = 1; tag = "R6"; end
    end else begin
      n = 16; tag = one ? "R10" : "R2";
    end
    p = ea + 2;
    per = n * p;
    cfg_a = 16'(a); cfg_b = 4'(b); cfg_divx_en = en; cfg_divx_one = one; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    observe(2 * per + 1, fs, fb, sb, sc, per);
    chk({tag, " cfg_err"}, int'(cfg_err), int'(err));
    chk({tag, " R8 first bit_tick"}, fb, per - 1);
    chk({tag, " bit period"}, sb - fb, per);
    if (en && one) begin
      chk("R4 samp_tick silent", sc, 0);
      chk("R4 samp_tick first", fs, -1);
    end else begin
      chk("R5 samp_tick per bit", sc, n);
      chk("R8 first samp_tick", fs, ea + 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int fs, fb, sb, sc, k;
    repeat (4) @(negedge clk);
    chk("R1 samp_tick in reset", int'(samp_tick), 0);
    chk("R1 bit_tick in reset", int'(bit_tick), 0);
    chk("R1 cfg_err in reset", int'(cfg_err), 0);
    rst_n = 1'b1;
    observe(64, fs, fb, sb, sc, 32);
    chk("R1 first samp_tick", fs, 1);
    chk("R1 first bit_tick", fb, 31);
    chk("R1 bit period", sb - fb, 32);

    for (int a = 0; a < 6; a++) begin
      run_cfg(a, 3, 1'b0, 1'b0);
      run_cfg(a, 0, 1'b0, 1'b1);
    end
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 16; b++)
        run_cfg(a, b, 1'b1, 1'b0);
    for (int a = 0; a < 8; a++)
      run_cfg(a, 5, 1'b1, 1'b1);
    run_cfg(300, 0, 1'b1, 1'b1);
    run_cfg(2, 15, 1'b1, 1'b0);

    // R9: write lands on a terminal count
    run_cfg(3, 0, 1'b1, 1'b1);
    k = 0;
    while (!bit_tick && k < 20) begin @(negedge clk); k++; end
    chk("R9 strobe present at write", int'(bit_tick), 1);
    cfg_a = 16'd5; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    observe(20, fs, fb, sb, sc, 7);
    chk("R9 next bit_tick after coincident write", fb, 6);
    chk("R9 period after coincident write", sb - fb, 7);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule